// File: doc/BRIEF.md
# Watchdog Timer with Shared Prescaler Clear

This block is a watchdog timer for a small microcontroller subsystem. A free-running prescaler counter runs on the fast (four-times bus) clock. Each time its low stages roll over, it sends a tick to a small watchdog counter. Software services the watchdog by writing to the top address of the memory map. The written data plays no part, so the block watches only the write strobe and the address.

A service does two things. It zeroes the watchdog counter. It also zeroes a middle band of prescaler stages, while the lowest five stages keep counting. If software stops servicing, the watchdog counter eventually rolls over. The block then sends a one-cycle reset request to the reset controller.

While a debug break is active and the break-freeze enable is set, the watchdog counter holds its value and no request can be raised. The prescaler keeps running during a freeze.

Top module: `wdog_prescale_top`

## Requirements
- R1: A cycle with `busWrStb` high and `busAddr` equal to `SVC_ADDR` (default 0xFFFF) zeroes the watchdog counter, and no timeout request follows from that cycle.
- R2: A service cycle loads the prescaler with its incremented value, with bits `PRE_W-1` down to 5 forced to zero (default bits 12..5). Bits 4..0 keep incrementing.
- R3: A watchdog tick occurs on each clock edge at which prescaler bits `TICK_BIT-1..0` are all ones. This gives one tick every 2^`TICK_BIT` cycles (default 4096) when no service occurs. The first tick after reset comes at edge 2^`TICK_BIT`.
- R4: The tick that takes the `WD_W`-bit watchdog counter (default 6 bits) from its maximum value to zero raises `timeoutReq` after that same edge. The request is high for exactly one cycle.
- R5: While `brkActive` and `brkWdogDis` are both high, ticks do not advance the watchdog counter and no timeout request is raised.
- R6: `brkActive` alone, or `brkWdogDis` alone, does not freeze the watchdog.
- R7: A write strobe to any address other than `SVC_ADDR` changes neither counter.
- R8: While `rstN` is low, both counters are zero and `timeoutReq` is low.
- R9: After a timeout the watchdog counter keeps counting from zero. Without service, the next request follows 2^`WD_W` ticks later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast (4x bus) clock |
| rstN | input | 1 | Asynchronous active-low system reset |
| busWrStb | input | 1 | Bus write strobe, one cycle per write |
| busAddr | input | ADDR_W | Bus write address |
| brkActive | input | 1 | Debug break in monitor mode is active |
| brkWdogDis | input | 1 | Enable bit: freeze the watchdog during a break |
| timeoutReq | output | 1 | One-cycle reset request on watchdog overflow |

## Verification
The assertions assume that `busWrStb` is sampled on clock edges and that every write lasts a single cycle. They also assume the break inputs are synchronous to `clk`. The stimulus changes every input only on the falling edge, and it drives each write strobe for exactly one cycle. Several scenarios place the service write or a break window on top of a tick edge. This exercises the priority of a service over a tick, and of a freeze over a tick. The bench builds the block with a short prescaler, so that full timeout periods fit within the run.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  // Strobes sent from the control module to the datapath
  typedef struct packed {
    logic svcClr;       // service write: clear watchdog and prescaler band
    logic cntInc;       // advance the watchdog counter by one
    logic fireTimeout;  // this advance wraps the counter: raise request
  } wdogStrobes_t;

  // Status returned from the datapath to the control module
  typedef struct packed {
    logic preTap;   // prescaler low stages are all ones this cycle
    logic wdAtMax;  // watchdog counter holds its maximum value
  } wdogStatus_t;

endpackage

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] SVC_ADDR = '1
) (
  input  logic              busWrStb,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              brkActive,
  input  logic              brkWdogDis,
  input  wdogStatus_t       status,
  output wdogStrobes_t      strobes
);

  logic svcHit;
  logic frozen;

  assign svcHit = busWrStb && (busAddr == SVC_ADDR);
  assign frozen = brkActive && brkWdogDis;

  // A service beats a tick; a freeze blocks the tick entirely
  always_comb begin
    strobes.svcClr      = svcHit;
    strobes.cntInc      = status.preTap && !frozen && !svcHit;
    strobes.fireTimeout = status.preTap && !frozen && !svcHit && status.wdAtMax;
  end

endmodule

// File: rtl/wdog_datapath.sv
module wdog_datapath
  import wdog_pkg::*;
#(
  parameter int unsigned PRE_W    = 13,
  parameter int unsigned TICK_BIT = 12,
  parameter int unsigned CLR_LO   = 5,
  parameter int unsigned WD_W     = 6
) (
  input  logic         clk,
  input  logic         rstN,
  input  wdogStrobes_t strobes,
  output wdogStatus_t  status,
  output logic         timeoutReq
);

  localparam int unsigned CLR_HI = PRE_W - 1;
  localparam logic [WD_W-1:0] WD_MAX = '1;

  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] preNext;
  logic [WD_W-1:0]  wdCnt;

  always_comb begin
    preNext = preCnt + 1'b1;
    if (strobes.svcClr) preNext[CLR_HI:CLR_LO] = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) preCnt <= '0;
    else       preCnt <= preNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                wdCnt <= '0;
    else if (strobes.svcClr)  wdCnt <= '0;
    else if (strobes.cntInc)  wdCnt <= wdCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) timeoutReq <= 1'b0;
    else       timeoutReq <= strobes.fireTimeout;
  end

  assign status.preTap  = &preCnt[TICK_BIT-1:0];
  assign status.wdAtMax = (wdCnt == WD_MAX);

  // R1: a service leaves the watchdog at zero with no request
  a_r1_service_clears: assert property (@(posedge clk) disable iff (!rstN)
    strobes.svcClr |=> (wdCnt == '0) && !timeoutReq);

  // R2: the middle band is zero after a service
  a_r2_band_zero: assert property (@(posedge clk) disable iff (!rstN)
    strobes.svcClr |=> (preCnt[CLR_HI:CLR_LO] == '0));

  // R2: the low stages keep counting through a service
  a_r2_low_counts: assert property (@(posedge clk) disable iff (!rstN)
    strobes.svcClr |=> (preCnt[CLR_LO-1:0] == $past(preCnt[CLR_LO-1:0]) + 1'b1));

  // R3: the watchdog counter only advances on a prescaler tap
  a_r3_tick_only: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(wdCnt) && wdCnt != '0) |-> $past(status.preTap));

  // R4: the request never lasts two cycles
  a_r4_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    timeoutReq |=> !timeoutReq);

  // R4: a request appears only after the counter wraps to zero
  a_r4_after_wrap: assert property (@(posedge clk) disable iff (!rstN)
    timeoutReq |-> (wdCnt == '0) && ($past(wdCnt) == WD_MAX));

endmodule

// File: rtl/wdog_prescale_top.sv
module wdog_prescale_top
  import wdog_pkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] SVC_ADDR = '1,
  parameter int unsigned PRE_W    = 13,
  parameter int unsigned TICK_BIT = 12,
  parameter int unsigned CLR_LO   = 5,
  parameter int unsigned WD_W     = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrStb,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              brkActive,
  input  logic              brkWdogDis,
  output logic              timeoutReq
);

  wdogStrobes_t strobes;
  wdogStatus_t  status;

  wdog_ctrl #(
    .ADDR_W  (ADDR_W),
    .SVC_ADDR(SVC_ADDR)
  ) uCtrl (
    .busWrStb  (busWrStb),
    .busAddr   (busAddr),
    .brkActive (brkActive),
    .brkWdogDis(brkWdogDis),
    .status    (status),
    .strobes   (strobes)
  );

  wdog_datapath #(
    .PRE_W   (PRE_W),
    .TICK_BIT(TICK_BIT),
    .CLR_LO  (CLR_LO),
    .WD_W    (WD_W)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .status    (status),
    .timeoutReq(timeoutReq)
  );

  // R5: a frozen watchdog raises no request on the next edge
  a_r5_frozen_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (brkActive && brkWdogDis) |=> !timeoutReq);

  // R7: a write to another address never raises a request by itself
  a_r7_other_addr: assert property (@(posedge clk) disable iff (!rstN)
    (busWrStb && busAddr != SVC_ADDR && !strobes.cntInc) |=> !timeoutReq);

endmodule

// File: tb/tb_wdog_prescale_top.sv
module tb_wdog_prescale_top;

  localparam int TB_PRE_W = 8;
  localparam int TB_TICK  = 7;
  localparam int WINDOW   = 12000;

  typedef struct packed {
    int          wrEdge;   // 0 = no write
    logic [15:0] wrAddr;
    int          brkStart;
    int          brkLen;
    logic        brkEn;
    int          expEdge;  // 0 = no timeout expected in window
  } vec_t;

  // Tick period 128; timeout after service at edge W: W+128-(W%32)+63*128
  localparam vec_t VECS [10] = '{
    '{0,    16'h0000, 0,    0,     1'b0, 8192},  // R3 R4 free run
    '{1000, 16'hFFFF, 0,    0,     1'b0, 9184},  // R1 R2 service
    '{3000, 16'hFFFF, 0,    0,     1'b0, 11168}, // R1 R2 late service
    '{1000, 16'hFFFE, 0,    0,     1'b0, 8192},  // R7 neighbour address
    '{1000, 16'h7FFF, 0,    0,     1'b0, 8192},  // R7 other address
    '{0,    16'h0000, 1,    WINDOW,1'b1, 0},     // R5 frozen throughout
    '{0,    16'h0000, 1000, 512,   1'b1, 8704},  // R5 four ticks frozen
    '{0,    16'h0000, 1,    WINDOW,1'b0, 8192},  // R6 break without enable
    '{128,  16'hFFFF, 0,    0,     1'b0, 8320},  // R1 service on tick edge
    '{0,    16'h0000, 0,    0,     1'b1, 8192}   // R6 enable without break
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrStb = 1'b0;
  logic [15:0] busAddr = '0;
  logic        brkActive = 1'b0;
  logic        brkWdogDis = 1'b0;
  logic        timeoutReq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  wdog_prescale_top #(
    .ADDR_W  (16),
    .SVC_ADDR(16'hFFFF),
    .PRE_W   (TB_PRE_W),
    .TICK_BIT(TB_TICK),
    .CLR_LO  (5),
    .WD_W    (6)
  ) dut (
    .clk       (clk),
    .rstN      (rstN),
    .busWrStb  (busWrStb),
    .busAddr   (busAddr),
    .brkActive (brkActive),
    .brkWdogDis(brkWdogDis),
    .timeoutReq(timeoutReq)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    busWrStb = 1'b0;
    brkActive = 1'b0;
    brkWdogDis = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int firstEdge;
    int widthBad;
    int secondEdge;

    // R8: reset state
    rstN = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R8 reset output", int'(timeoutReq), 0);

    foreach (VECS[v]) begin
      doReset();
      firstEdge = 0;
      widthBad  = 0;
      for (int e = 1; e <= WINDOW; e++) begin
        busWrStb   = (e == VECS[v].wrEdge);
        busAddr    = VECS[v].wrAddr;
        brkActive  = (VECS[v].brkLen > 0) && (e >= VECS[v].brkStart) &&
                     (e < VECS[v].brkStart + VECS[v].brkLen);
        brkWdogDis = VECS[v].brkEn;
        @(posedge clk);
        #1;
        if (timeoutReq && firstEdge == 0) firstEdge = e;
        else if (timeoutReq && e == firstEdge + 1) widthBad = 1;
        @(negedge clk);
      end
      busWrStb = 1'b0;
      check($sformatf("R4 vector %0d timeout edge", v), firstEdge, VECS[v].expEdge);
      check($sformatf("R4 vector %0d pulse width", v), widthBad, 0);
    end

    // R9: next timeout 64 ticks after the first; R8: reset restarts timing
    doReset();
    firstEdge  = 0;
    secondEdge = 0;
    for (int e = 1; e <= 16400; e++) begin
      @(posedge clk);
      #1;
      if (timeoutReq) begin
        if (firstEdge == 0) firstEdge = e;
        else if (secondEdge == 0) secondEdge = e;
      end
      @(negedge clk);
    end
    check("R8 first timeout after reset", firstEdge, 8192);
    check("R9 second timeout", secondEdge, 16384);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule